// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This adapter connects a 32-bit host port to a 512-byte peripheral register space whose registers do not all share one width. The space is split into 4-byte regions. A region table, set by a parameter, gives each region a native width of one byte, one halfword or one word, or marks it as a hole. Each host access is a byte, halfword or word access. The adapter turns it into the sequence of native-width accesses on a simple back-end port, which is where the registers themselves are attached.

An access that is wider than the native registers is split into several native accesses at ascending addresses. An access that is narrower than or equal to the native width becomes one native read, and the addressed lane is returned. A narrow write to a wide register is done as a read-merge-write: the adapter reads the native register, replaces only the addressed lanes and writes the whole value back. Lane order is big-endian throughout, so the lower byte address always sits in the more significant bits. A sequencer issues one back-end access at a time and pulses `done` once the whole host access has finished.

Top module: `mwba_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the register offset. Higher address bits have no effect on the access.
- R2: The access ends with `rsp_err`=1, `rsp_rdata`=0 and no back-end access at all if any of these holds: the size code is 3, the offset is 0x200 or above, the region is a hole, or the offset is not a multiple of the access size. Size codes are 0 for a byte, 1 for a halfword and 2 for a word.
- R3: The region table is indexed by offset bits 9:2. Its codes are 0 for a hole, 1 for byte, 2 for halfword and 3 for word. Every back-end access uses the native width of its region (`be_size` 0/1/2 = byte/half/word) and is aligned to that width. In the default table, regions 0–11 are byte, regions 12–15 are halfword, regions 48–63 are holes, regions 64–95 are byte, regions 96–127 are word, and regions 16–47 follow r mod 3 (0 word, 1 byte, 2 halfword).
- R4: A read no wider than the native width makes exactly one native read at the offset rounded down to the native width. It returns the addressed lane right-justified, and the lower address maps to the more significant bits.
- R5: A read wider than the native width makes (access size / native size) native reads at ascending addresses from the offset. The first result goes into the most significant part of `rsp_rdata`.
- R6: A write wider than the native width makes (access size / native size) native writes at ascending addresses. The most significant part of the host data goes to the lowest address.
- R7: A write narrower than the native width makes one native read and then one native write to the same aligned address. Only the addressed lanes change. A write of equal width makes one native write.
- R8: At most one back-end access is in flight. Its address, size, direction and data hold steady until `be_ready`. `done` is a single-cycle pulse one cycle after the final back-end handshake, or one cycle after acceptance for an error.
- R9: `req_valid` is accepted only while `host_idle` is high. A request presented while the adapter is busy is ignored.
- R10: After reset, `host_idle`=1, `done`=0 and `be_valid`=0. `rsp_rdata` reads as zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request, taken when `host_idle` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | HOST_AW | Host byte address; low 10 bits used |
| req_wdata | input | 32 | Write data, right-justified |
| host_idle | output | 1 | Adapter ready for a new request |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Bus error, valid with `done` |
| rsp_rdata | output | 32 | Read data, right-justified, valid with `done` |
| be_valid | output | 1 | Back-end access request |
| be_we | output | 1 | Back-end write |
| be_size | output | 2 | Back-end native size code |
| be_addr | output | 10 | Back-end byte offset |
| be_wdata | output | 32 | Back-end write data, right-justified |
| be_ready | input | 1 | Back-end completes the current access |
| be_rdata | input | 32 | Back-end read data, valid with `be_ready` |

## Verification
The checker watches the back-end handshake on every cycle. It checks that the payload is held while `be_ready` is low and that every back-end access has a legal native size, is aligned and stays inside the space. It also checks that `done` is a one-cycle pulse, that an error response follows acceptance directly, and that a successful response follows a back-end handshake. The scenarios show what the checker cannot see. These are the big-endian lane placement in split and narrowed reads, the exact count, order and direction of the native accesses, and whether a read-merge-write leaves the neighbouring lanes of the wide register intact. They also show that a request offered while busy leaves memory untouched. The bench checks all of this against its own byte-array model of the register space.

// File: rtl/mwba_pkg.sv
package mwba_pkg;

    localparam int OFS_W   = 10;
    localparam int REGIONS = 1 << (OFS_W - 2);
    localparam int DW      = 32;

    typedef enum logic [1:0] {
        NW_HOLE = 2'd0,
        NW_BYTE = 2'd1,
        NW_HALF = 2'd2,
        NW_WORD = 2'd3
    } natw_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } asz_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_XFER     = 3'd1,
        ST_MERGE_WR = 3'd2,
        ST_RESP     = 3'd3
    } st_e;

    typedef struct packed {
        st_e              st;
        logic             we;
        logic             rmw;
        logic             err;
        logic [1:0]       bsz;
        logic [2:0]       sb;
        logic [2:0]       wb;
        logic [1:0]       off;
        logic [2:0]       beats;
        logic [2:0]       idx;
        logic [OFS_W-1:0] base;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    acc;
    } seq_t;

    // Width code of one 4-byte region in the default layout.
    function automatic logic [1:0] region_code(int r);
        logic [1:0] c;
        if (r < 12)       c = NW_BYTE;
        else if (r < 16)  c = NW_HALF;
        else if (r < 48) begin
            case (r % 3)
                0:       c = NW_WORD;
                1:       c = NW_BYTE;
                default: c = NW_HALF;
            endcase
        end
        else if (r < 64)  c = NW_HOLE;
        else if (r < 96)  c = NW_BYTE;
        else if (r < 128) c = NW_WORD;
        else              c = NW_HOLE;
        return c;
    endfunction

    function automatic logic [2*REGIONS-1:0] default_map();
        logic [2*REGIONS-1:0] m;
        m = '0;
        for (int r = 0; r < REGIONS; r++) begin
            m[2*r +: 2] = region_code(r);
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [2:0] nbytes);
        logic [DW-1:0] m;
        case (nbytes)
            3'd1:    m = DW'(32'h0000_00FF);
            3'd2:    m = DW'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

    // Bit shift of a lane of sb bytes at byte offset off inside a
    // native value of wb bytes, big-endian lane order.
    function automatic logic [5:0] lane_shift(logic [2:0] wb, logic [1:0] off,
                                              logic [2:0] sb);
        return 6'((int'(wb) - int'(off) - int'(sb)) * 8);
    endfunction

    function automatic logic [DW-1:0] pick_lane(logic [DW-1:0] nat, logic [2:0] wb,
                                                logic [1:0] off, logic [2:0] sb);
        return (nat >> lane_shift(wb, off, sb)) & lane_mask(sb);
    endfunction

    function automatic logic [DW-1:0] merge_lane(logic [DW-1:0] nat, logic [2:0] wb,
                                                 logic [1:0] off, logic [2:0] sb,
                                                 logic [DW-1:0] val);
        logic [5:0]    sh;
        logic [DW-1:0] m;
        sh = lane_shift(wb, off, sb);
        m  = lane_mask(sb) << sh;
        return (nat & ~m) | ((val & lane_mask(sb)) << sh);
    endfunction

endpackage

// File: rtl/mwba_decode.sv
module mwba_decode
    import mwba_pkg::*;
#(
    parameter int                   SPACE_LIMIT = 32'h200,
    parameter logic [2*REGIONS-1:0] WIDTH_MAP   = default_map()
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output logic             dec_err,
    output logic [1:0]       dec_bsz,
    output logic [2:0]       dec_sb,
    output logic [2:0]       dec_wb,
    output logic [1:0]       dec_off,
    output logic [2:0]       dec_beats,
    output logic [OFS_W-1:0] dec_start
);
    localparam logic [OFS_W:0] LIM = (OFS_W+1)'(SPACE_LIMIT);

    logic [1:0]       code;
    logic [1:0]       amask;
    logic             split;
    logic [OFS_W-1:0] wmask;

    always_comb begin
        code      = WIDTH_MAP[{ofs[OFS_W-1:2], 1'b0} +: 2];
        dec_bsz   = code - 2'd1;
        dec_sb    = 3'd1 << size;
        dec_wb    = (code == NW_HOLE) ? 3'd0 : (3'd1 << dec_bsz);
        amask     = 2'(dec_sb - 3'd1);
        dec_err   = (size == SZ_BAD) || ({1'b0, ofs} >= LIM) ||
                    (code == NW_HOLE) || ((ofs[1:0] & amask) != 2'd0);
        split     = dec_sb > dec_wb;
        dec_beats = split ? (dec_sb >> dec_bsz) : 3'd1;
        wmask     = OFS_W'(dec_wb - 3'd1);
        dec_start = split ? ofs : (ofs & ~wmask);
        dec_off   = ofs[1:0] - dec_start[1:0];
    end
endmodule

// File: rtl/mwba_seq.sv
module mwba_seq
    import mwba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [DW-1:0]    req_wdata,
    input  logic             dec_err,
    input  logic [1:0]       dec_bsz,
    input  logic [2:0]       dec_sb,
    input  logic [2:0]       dec_wb,
    input  logic [1:0]       dec_off,
    input  logic [2:0]       dec_beats,
    input  logic [OFS_W-1:0] dec_start,
    output logic             host_idle,
    output logic             done,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic             be_valid,
    output logic             be_we,
    output logic [1:0]       be_size,
    output logic [OFS_W-1:0] be_addr,
    output logic [DW-1:0]    be_wdata,
    input  logic             be_ready,
    input  logic [DW-1:0]    be_rdata
);
    seq_t          q, d;
    logic [5:0]    slice_sh;
    logic [DW-1:0] nat_rd;
    logic          last_beat;

    always_comb begin
        d         = q;
        host_idle = (q.st == ST_IDLE);
        done      = (q.st == ST_RESP);
        rsp_err   = done && q.err;
        rsp_rdata = (done && !q.err && !q.we) ? q.acc : '0;
        be_valid  = (q.st == ST_XFER) || (q.st == ST_MERGE_WR);
        be_we     = ((q.st == ST_XFER) && q.we && !q.rmw) || (q.st == ST_MERGE_WR);
        be_size   = q.bsz;
        be_addr   = q.base + (OFS_W'(q.idx) << q.bsz);
        slice_sh  = 6'((int'(q.beats) - 1 - int'(q.idx)) * int'(q.wb) * 8);
        be_wdata  = (q.st == ST_MERGE_WR) ? q.acc
                                          : ((q.wdata >> slice_sh) & lane_mask(q.wb));
        nat_rd    = be_rdata & lane_mask(q.wb);
        last_beat = (q.idx == q.beats - 3'd1);

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.we    = req_we;
                    d.err   = dec_err;
                    d.bsz   = dec_bsz;
                    d.sb    = dec_sb;
                    d.wb    = dec_wb;
                    d.off   = dec_off;
                    d.beats = dec_beats;
                    d.idx   = 3'd0;
                    d.base  = dec_start;
                    d.wdata = req_wdata & lane_mask(dec_sb);
                    d.acc   = '0;
                    d.rmw   = req_we && !dec_err && (dec_sb < dec_wb);
                    d.st    = dec_err ? ST_RESP : ST_XFER;
                end
            end
            ST_XFER: begin
                if (be_ready) begin
                    if (!q.we) begin
                        if (q.beats > 3'd1) d.acc = (q.acc << {q.wb, 3'b000}) | nat_rd;
                        else                d.acc = pick_lane(nat_rd, q.wb, q.off, q.sb);
                    end
                    if (q.rmw) begin
                        d.acc = merge_lane(nat_rd, q.wb, q.off, q.sb, q.wdata);
                        d.st  = ST_MERGE_WR;
                    end else if (last_beat) begin
                        d.st = ST_RESP;
                    end else begin
                        d.idx = q.idx + 3'd1;
                    end
                end
            end
            ST_MERGE_WR: begin
                if (be_ready) d.st = ST_RESP;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mwba_adapter.sv
module mwba_adapter
    import mwba_pkg::*;
#(
    parameter int                   HOST_AW     = 16,
    parameter int                   SPACE_LIMIT = 32'h200,
    parameter logic [2*REGIONS-1:0] WIDTH_MAP   = default_map()
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [1:0]         req_size,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               host_idle,
    output logic               done,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata,
    output logic               be_valid,
    output logic               be_we,
    output logic [1:0]         be_size,
    output logic [OFS_W-1:0]   be_addr,
    output logic [DW-1:0]      be_wdata,
    input  logic               be_ready,
    input  logic [DW-1:0]      be_rdata
);
    logic             dec_err;
    logic [1:0]       dec_bsz;
    logic [2:0]       dec_sb;
    logic [2:0]       dec_wb;
    logic [1:0]       dec_off;
    logic [2:0]       dec_beats;
    logic [OFS_W-1:0] dec_start;
    logic             unused_addr_hi;

    generate
        if (HOST_AW > OFS_W) begin : g_hi
            assign unused_addr_hi = ^req_addr[HOST_AW-1:OFS_W];
        end else begin : g_nohi
            assign unused_addr_hi = 1'b0;
        end
    endgenerate

    mwba_decode #(
        .SPACE_LIMIT(SPACE_LIMIT),
        .WIDTH_MAP  (WIDTH_MAP)
    ) u_dec (
        .ofs      (req_addr[OFS_W-1:0]),
        .size     (req_size),
        .dec_err  (dec_err),
        .dec_bsz  (dec_bsz),
        .dec_sb   (dec_sb),
        .dec_wb   (dec_wb),
        .dec_off  (dec_off),
        .dec_beats(dec_beats),
        .dec_start(dec_start)
    );

    mwba_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_wdata(req_wdata),
        .dec_err  (dec_err),
        .dec_bsz  (dec_bsz),
        .dec_sb   (dec_sb),
        .dec_wb   (dec_wb),
        .dec_off  (dec_off),
        .dec_beats(dec_beats),
        .dec_start(dec_start),
        .host_idle(host_idle),
        .done     (done),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata),
        .be_valid (be_valid),
        .be_we    (be_we),
        .be_size  (be_size),
        .be_addr  (be_addr),
        .be_wdata (be_wdata),
        .be_ready (be_ready),
        .be_rdata (be_rdata)
    );
endmodule

// File: rtl/mwba_checker.sv
module mwba_checker
    import mwba_pkg::*;
#(
    parameter int SPACE_LIMIT = 32'h200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             host_idle,
    input logic             done,
    input logic             rsp_err,
    input logic [DW-1:0]    rsp_rdata,
    input logic             be_valid,
    input logic             be_we,
    input logic [1:0]       be_size,
    input logic [OFS_W-1:0] be_addr,
    input logic [DW-1:0]    be_wdata,
    input logic             be_ready
);
    localparam logic [OFS_W:0] LIM = (OFS_W+1)'(SPACE_LIMIT);

    logic [1:0] amask;
    assign amask = (be_size == 2'd0) ? 2'd0 : (be_size == 2'd1) ? 2'd1 : 2'd3;

    a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && !be_ready |=> be_valid && $stable(be_addr) && $stable(be_we)
                                  && $stable(be_size) && $stable(be_wdata));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done && !rsp_err |-> $past(be_valid && be_ready));

    a_r8_idle_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        host_idle |-> !be_valid);

    a_r9_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        host_idle && req_valid |=> !host_idle);

    a_r2_err_direct: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> done && rsp_rdata == '0 && $past(host_idle && req_valid));

    a_r3_native_legal: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> be_size != 2'd3 && ({1'b0, be_addr} < LIM)
                     && ((be_addr[1:0] & amask) == 2'd0));
endmodule

bind mwba_adapter mwba_checker #(.SPACE_LIMIT(SPACE_LIMIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .host_idle(host_idle),
    .done     (done),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .be_valid (be_valid),
    .be_we    (be_we),
    .be_size  (be_size),
    .be_addr  (be_addr),
    .be_wdata (be_wdata),
    .be_ready (be_ready)
);

// File: tb/mwba_adapter_test.sv
`timescale 1ns/1ps
module mwba_adapter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        host_idle, done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        be_valid, be_we;
    logic [1:0]  be_size;
    logic [9:0]  be_addr;
    logic [31:0] be_wdata;
    logic        be_ready = 1'b0;
    logic [31:0] be_rdata = '0;

    int total = 0;
    int bad = 0;

    logic [7:0] mem     [0:1023];
    logic [7:0] ref_mem [0:1023];

    // expectations shared with the back-end model
    int    exp_bsz, exp_addr, exp_step, bus_cnt, wait_cnt;
    bit    exp_we, exp_rmw;
    string cur_tag = "R4";

    always #2.5 clk = ~clk;

    mwba_adapter uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .host_idle(host_idle), .done(done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .be_valid(be_valid), .be_we(be_we), .be_size(be_size), .be_addr(be_addr),
        .be_wdata(be_wdata), .be_ready(be_ready), .be_rdata(be_rdata)
    );

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Native width in bytes of a region, from the R3 default table.
    function automatic int region_bytes(int r);
        if (r < 12) return 1;
        if (r < 16) return 2;
        if (r < 48) return (r % 3 == 0) ? 4 : ((r % 3 == 1) ? 1 : 2);
        if (r < 64) return 0;
        if (r < 96) return 1;
        if (r < 128) return 4;
        return 0;
    endfunction

    // Back-end register model, driven away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            be_ready = 1'b0;
            wait_cnt = 0;
        end else if (be_ready) begin
            be_ready = 1'b0;
            wait_cnt = int'($urandom % 3);
        end else if (be_valid) begin
            if (wait_cnt != 0) begin
                wait_cnt--;
            end else begin
                int  nb;
                bit  wexp;
                logic [31:0] v;
                nb   = 1 << be_size;
                wexp = exp_rmw ? (bus_cnt == 1) : exp_we;
                check(int'(be_size) == exp_bsz, "R3", "native size", 32'(be_size), 32'(exp_bsz));
                check(int'(be_addr) == exp_addr, cur_tag, "beat address", 32'(be_addr), 32'(exp_addr));
                check(be_we == wexp, cur_tag, "beat direction", 32'(be_we), 32'(wexp));
                if (be_we) begin
                    for (int b = 0; b < nb; b++)
                        mem[int'(be_addr) + b] = be_wdata[(nb-1-b)*8 +: 8];
                end else begin
                    v = '0;
                    for (int b = 0; b < nb; b++) v = (v << 8) | 32'(mem[int'(be_addr) + b]);
                    be_rdata = v;
                end
                be_ready = 1'b1;
                bus_cnt++;
                exp_addr += exp_step;
            end
        end
    end

    task automatic run(logic [15:0] a, logic [1:0] sz, bit we, logic [31:0] wd, bit inject);
        int ofs, sb, wb, exp_cnt, c;
        bit experr, split;
        logic [31:0] exp_rd;
        ofs = int'(a[9:0]);
        sb  = 1 << sz;
        wb  = region_bytes(ofs >> 2);
        experr = (sz == 2'd3) || (ofs >= 'h200) || (wb == 0) || (ofs % sb != 0);
        split  = sb > wb;
        exp_rmw = !experr && we && (sb < wb);
        exp_we  = we;
        exp_bsz = (wb == 4) ? 2 : ((wb == 2) ? 1 : 0);
        exp_step = split ? wb : 0;
        exp_addr = split ? ofs : (wb == 0 ? ofs : ofs - (ofs % wb));
        exp_cnt  = experr ? 0 : (split ? sb / wb : (exp_rmw ? 2 : 1));
        cur_tag  = split ? (we ? "R6" : "R5") : (exp_rmw ? "R7" : "R4");
        exp_rd = '0;
        if (!experr && !we)
            for (int b = 0; b < sb; b++) exp_rd = (exp_rd << 8) | 32'(ref_mem[ofs + b]);
        bus_cnt = 0;
        while (!host_idle) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            req_valid = 1'b1; req_we = 1'b1; req_size = 2'd0;
            req_addr = 16'h0101; req_wdata = 32'(~ref_mem['h101]);
            @(negedge clk);
            req_valid = 1'b0;
        end
        c = 0;
        while (!done && c < 400) begin @(negedge clk); c++; end
        check(done, "R8", "completion", 32'(done), 32'd1);
        check(rsp_err == experr, "R2", "error flag", 32'(rsp_err), 32'(experr));
        check(rsp_rdata == exp_rd, experr ? "R2" : (we ? "R10" : cur_tag), "read data",
              rsp_rdata, exp_rd);
        check(bus_cnt == exp_cnt, experr ? "R2" : cur_tag, "back-end access count",
              32'(bus_cnt), 32'(exp_cnt));
        if (!experr && we)
            for (int b = 0; b < sb; b++) ref_mem[ofs + b] = wd[(sb-1-b)*8 +: 8];
        if (we && ofs < 'h200)
            for (int b = 0; b < 4; b++)
                check(mem[(ofs & ~3) + b] == ref_mem[(ofs & ~3) + b],
                      experr ? "R2" : cur_tag, "region byte after write",
                      32'(mem[(ofs & ~3) + b]), 32'(ref_mem[(ofs & ~3) + b]));
        if (inject)
            check(mem['h101] == ref_mem['h101], "R9", "busy request ignored",
                  32'(mem['h101]), 32'(ref_mem['h101]));
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'($urandom);
            ref_mem[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        // R10 reset state
        check(host_idle == 1'b1, "R10", "idle in reset", 32'(host_idle), 32'd1);
        check(done == 1'b0, "R10", "done in reset", 32'(done), 32'd0);
        check(be_valid == 1'b0, "R10", "be_valid in reset", 32'(be_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_idle == 1'b1, "R10", "idle after reset", 32'(host_idle), 32'd1);

        // directed corners
        run(16'h0004, 2'd2, 1'b0, 32'h0, 1'b0);          // R5 word from bytes
        run(16'h000A, 2'd1, 1'b0, 32'h0, 1'b0);          // R5 half from bytes
        run(16'h0030, 2'd0, 1'b0, 32'h0, 1'b0);          // R4 even byte of half
        run(16'h0031, 2'd0, 1'b0, 32'h0, 1'b0);          // R4 odd byte of half
        for (int k = 0; k < 4; k++)
            run(16'h0048 + 16'(k), 2'd0, 1'b0, 32'h0, 1'b0); // R4 bytes of word
        run(16'h004A, 2'd1, 1'b0, 32'h0, 1'b0);          // R4 low half of word
        run(16'h0030, 2'd2, 1'b0, 32'h0, 1'b0);          // R5 word from halves
        run(16'h0049, 2'd0, 1'b1, 32'hFFFF_FFA5, 1'b0);  // R7 byte into word
        run(16'h0048, 2'd1, 1'b1, 32'h0000_1234, 1'b0);  // R7 half into word
        run(16'h0033, 2'd0, 1'b1, 32'h0000_00C3, 1'b0);  // R7 byte into half
        run(16'h0100, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0);  // R6 word into bytes
        run(16'h003C, 2'd2, 1'b1, 32'hCAFE_F00D, 1'b0);  // R6 word into halves
        run(16'h0180, 2'd2, 1'b1, 32'h0BAD_CAFE, 1'b0);  // R7 equal width write
        run(16'h0200, 2'd0, 1'b0, 32'h0, 1'b0);          // R2 out of range
        run(16'h00C4, 2'd2, 1'b1, 32'h1111_1111, 1'b0);  // R2 hole
        run(16'h0031, 2'd1, 1'b0, 32'h0, 1'b0);          // R2 misaligned
        run(16'h0008, 2'd3, 1'b1, 32'h2222_2222, 1'b0);  // R2 size code 3
        run(16'hFC48, 2'd2, 1'b0, 32'h0, 1'b0);          // R1 upper bits ignored
        run(16'h0648, 2'd2, 1'b0, 32'h0, 1'b0);          // R1 bit 9 set -> R2 error
        run(16'h0180, 2'd2, 1'b0, 32'h0, 1'b1);          // R9 request while busy

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            logic [1:0]  sz;
            int r;
            a = 16'($urandom);
            r = int'($urandom % 10);
            sz = (r < 3) ? 2'd0 : (r < 6) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
            if ($urandom % 8 != 0) begin
                if (sz == 2'd1) a[0] = 1'b0;
                if (sz == 2'd2) a[1:0] = 2'b00;
            end
            if ($urandom % 4 != 0) a[9] = 1'b0;
            run(a, sz, 1'($urandom), $urandom, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule